// File: doc/BRIEF.md
# Ternary Weight Dot-Product Accumulator

This block forms the dot product of a stream of signed integer activations with a stream of balanced-ternary weights. It has no multiplier. On each accepted term the weight code chooses one of three paths for the activation. Weight +1 adds the activation to the running sum as it is. Weight -1 adds its negation. Weight 0 leaves the sum alone.

A producer presents one activation and one 2-bit weight code per cycle under a valid strobe. A start pulse opens a new dot product, and a last flag closes it. One cycle after the last term is taken, the block raises a single-cycle done strobe and presents four results: the sum, a saturation flag, the number of terms skipped for a zero weight, and the number of pad codes seen.

The results stay on the outputs until the next start. The accumulator is sized so that 8-bit activations over the full parameterised term count can never overflow. Any longer run clamps at the signed limits of the accumulator and sets a sticky flag.

Top module: `tern_dot_acc`

## Requirements
- R1: While reset is applied, and afterwards until the first stimulus, out_done, out_sum, out_sat, out_skip and out_pad are all zero.
- R2: An accepted term with weight code 2 (+1) adds the sign-extended activation to the sum unchanged.
- R3: An accepted term with weight code 1 (-1) subtracts the activation from the sum. This holds for an activation of -128, which contributes +128.
- R4: An accepted term with weight code 0 leaves the sum unchanged and increments the skip count, which is reported as out_skip with the result.
- R5: Weight code 3 is a pad. It leaves the sum unchanged and increments the pad count (out_pad), not the skip count.
- R6: A start pulse with in_valid low clears the sum, the saturation flag and both counts. A start pulse together with a valid term clears them and loads that term as the first contribution.
- R7: When a term flagged in_last is accepted, out_done is high for exactly the one following cycle. In that cycle the outputs hold the result, which includes that last term.
- R8: The result outputs hold their values until the next start. A start that does not close a dot product drives out_sum, out_sat, out_skip and out_pad to zero in the following cycle.
- R9: Cycles with in_valid low do not change the sum or the counts, whatever in_act, in_wcode and in_last carry.
- R10: If the sum would exceed the 19-bit signed range (+262143 / -262144 at default parameters), it clamps to that limit and out_sat is set. The flag stays set until the next start.
- R11: A dot product of up to 1024 terms of 8-bit activations, including 1024 terms of -128 with weight -1 (sum +131072), is exact and leaves out_sat clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The current term is present and is accepted this cycle |
| in_start | input | 1 | Begins a new dot product |
| in_last | input | 1 | Marks the final term of the dot product (used only with in_valid) |
| in_act | input | ACT_W | Signed activation |
| in_wcode | input | 2 | Weight code: 0 zero, 1 minus one, 2 plus one, 3 pad |
| out_done | output | 1 | Single-cycle strobe: result is valid |
| out_sum | output | ACC_W | Signed dot-product result |
| out_sat | output | 1 | The result was clamped at least once |
| out_skip | output | CNT_W | Number of zero-weight terms in this dot product |
| out_pad | output | CNT_W | Number of pad terms in this dot product |

## Verification
The term that carries in_last is taken on a rising edge, and the result registers load on that same edge. So out_done and the four result fields are due one cycle later. The bench drives inputs just after each rising edge and samples on the falling edge that follows the accepting edge.

Each sequence pushes its expected sum, flag and counts into a queue when its last term is driven. A monitor pops one entry on every falling edge where out_done is high. A done pulse that lasts two cycles therefore shows up as an unexpected result. Hold and clear checks are made on the falling edge after idle cycles and one cycle after a lone start pulse.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef enum logic [1:0] {
    WC_ZERO = 2'd0,
    WC_NEG  = 2'd1,
    WC_POS  = 2'd2,
    WC_PAD  = 2'd3
  } wcode_e;

  localparam int NUM_CNT  = 2;
  localparam int CNT_SKIP = 0;
  localparam int CNT_PAD  = 1;

endpackage

// File: rtl/tern_term_sel.sv
module tern_term_sel #(
  parameter int ACT_W = 8,
  parameter int ACC_W = 19
) (
  input  logic signed [ACT_W-1:0] act,
  input  logic [1:0]              wcode,
  output logic signed [ACC_W-1:0] term,
  output logic                    is_zero,
  output logic                    is_pad
);
  import tern_pkg::*;

  localparam int EXT_W = ACC_W - ACT_W;

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [ACT_W-1:0] a);
    return {{EXT_W{a[ACT_W-1]}}, a};
  endfunction

  function automatic logic signed [ACC_W-1:0] apply_weight(
    input logic signed [ACT_W-1:0] a,
    input logic [1:0]              w
  );
    logic signed [ACC_W-1:0] wide;
    wide = widen(a);
    case (wcode_e'(w))
      WC_POS:  return wide;
      WC_NEG:  return -wide;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    term    = apply_weight(act, wcode);
    is_zero = (wcode_e'(wcode) == WC_ZERO);
    is_pad  = (wcode_e'(wcode) == WC_PAD);
  end

endmodule

// File: rtl/tern_sat_acc.sv
module tern_sat_acc #(
  parameter int ACC_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step_en,
  input  logic signed [ACC_W-1:0] term,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_d,
  output logic                    sat_q,
  output logic                    sat_d
);

  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic [ACC_W:0] sat_add(
    input logic signed [ACC_W-1:0] a,
    input logic signed [ACC_W-1:0] b
  );
    logic signed [ACC_W:0] s;
    logic                  ovf;
    logic signed [ACC_W-1:0] r;
    s   = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    ovf = s[ACC_W] ^ s[ACC_W-1];
    if (ovf) r = s[ACC_W] ? MINV : MAXV;
    else     r = s[ACC_W-1:0];
    return {ovf, r};
  endfunction

  logic signed [ACC_W-1:0] base;
  logic                    base_sat;
  logic [ACC_W:0]          add_res;
  logic                    step_ovf;

  always_comb begin
    base     = load ? '0 : acc_q;
    base_sat = load ? 1'b0 : sat_q;
    add_res  = sat_add(base, term);
    step_ovf = step_en & add_res[ACC_W];
    acc_d    = step_en ? add_res[ACC_W-1:0] : base;
    sat_d    = base_sat | step_ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      sat_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      sat_q <= sat_d;
    end
  end

  a_r9_idle_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_en) |=> $stable(acc_q));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !load) |=> sat_q);

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !step_en) |=> (acc_q == '0 && !sat_q));

  a_r10_clamp_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && add_res[ACC_W]) |=> (acc_q == MAXV || acc_q == MINV));

endmodule

// File: rtl/tern_cnt.sv
module tern_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic en);
    if (en && c != CMAX) return c + 1'b1;
    return c;
  endfunction

  logic [CNT_W-1:0] base;

  always_comb begin
    base  = clr ? '0 : cnt_q;
    cnt_d = bump(base, inc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r9_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));

endmodule

// File: rtl/tern_dot_acc.sv
module tern_dot_acc #(
  parameter  int ACT_W     = 8,
  parameter  int MAX_TERMS = 1024,
  localparam int ACC_W     = ACT_W + $clog2(MAX_TERMS) + 1,
  localparam int CNT_W     = $clog2(MAX_TERMS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_start,
  input  logic                    in_last,
  input  logic signed [ACT_W-1:0] in_act,
  input  logic [1:0]              in_wcode,
  output logic                    out_done,
  output logic signed [ACC_W-1:0] out_sum,
  output logic                    out_sat,
  output logic [CNT_W-1:0]        out_skip,
  output logic [CNT_W-1:0]        out_pad
);
  import tern_pkg::*;

  logic signed [ACC_W-1:0] term;
  logic                    term_zero;
  logic                    term_pad;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    sat_q, sat_d;
  logic                    take_term;
  logic                    take_last;
  logic [NUM_CNT-1:0]      cnt_inc;
  logic [CNT_W-1:0]        cnt_q [NUM_CNT];
  logic [CNT_W-1:0]        cnt_d [NUM_CNT];

  assign take_term = in_valid;
  assign take_last = in_valid & in_last;
  assign cnt_inc[CNT_SKIP] = take_term & term_zero;
  assign cnt_inc[CNT_PAD]  = take_term & term_pad;

  tern_term_sel #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_sel (
    .act     (in_act),
    .wcode   (in_wcode),
    .term    (term),
    .is_zero (term_zero),
    .is_pad  (term_pad)
  );

  tern_sat_acc #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_start),
    .step_en (take_term),
    .term    (term),
    .acc_q   (acc_q),
    .acc_d   (acc_d),
    .sat_q   (sat_q),
    .sat_d   (sat_d)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tern_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (in_start),
      .inc   (cnt_inc[g]),
      .cnt_q (cnt_q[g]),
      .cnt_d (cnt_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done <= 1'b0;
      out_sum  <= '0;
      out_sat  <= 1'b0;
      out_skip <= '0;
      out_pad  <= '0;
    end else if (take_last) begin
      out_done <= 1'b1;
      out_sum  <= acc_d;
      out_sat  <= sat_d;
      out_skip <= cnt_d[CNT_SKIP];
      out_pad  <= cnt_d[CNT_PAD];
    end else if (in_start) begin
      out_done <= 1'b0;
      out_sum  <= '0;
      out_sat  <= 1'b0;
      out_skip <= '0;
      out_pad  <= '0;
    end else begin
      out_done <= 1'b0;
    end
  end

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> out_done);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !take_last |=> !out_done);

  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_last && !in_start) |=> ($stable(out_sum) && $stable(out_sat)
                                   && $stable(out_skip) && $stable(out_pad)));

  a_r5_pad_not_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (take_term && term_pad && !in_start) |=> $stable(cnt_q[CNT_SKIP]));

  a_r4_zero_keeps_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (take_term && (term_zero || term_pad) && !in_start && !sat_q) |=> $stable(acc_q));

endmodule

// File: tb/tern_dot_acc_bench.sv
module tern_dot_acc_bench;

  localparam int  ACT_W = 8;
  localparam int  ACC_W = 19;
  localparam int  CNT_W = 11;
  localparam longint LIM_HI = 262143;
  localparam longint LIM_LO = -262144;
  localparam int  CMAX = 2047;

  typedef struct {
    longint sum;
    bit     sat;
    int     skip;
    int     pad;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic signed [ACT_W-1:0] in_act = '0;
  logic [1:0] in_wcode = '0;
  logic out_done, out_sat;
  logic signed [ACC_W-1:0] out_sum;
  logic [CNT_W-1:0] out_skip, out_pad;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  exp_t scb[$];
  int va[];
  int vc[];
  longint last_sum = 0;

  always #2 clk = ~clk;

  tern_dot_acc u_tern_dot_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_act(in_act), .in_wcode(in_wcode),
    .out_done(out_done), .out_sum(out_sum), .out_sat(out_sat),
    .out_skip(out_skip), .out_pad(out_pad)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drv(input bit v, input bit s, input bit l, input int a, input int c);
    @(posedge clk);
    #1;
    in_valid = v; in_start = s; in_last = l;
    in_act = ACT_W'(a); in_wcode = 2'(c);
  endtask

  task automatic junk();
    drv(0, 0, 1'($urandom), int'($urandom % 256) - 128, int'($urandom % 4));
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0);
  endtask

  // Sends va/vc as one dot product; pushes the expected result.
  task automatic send(input bit sep, input int gap, input string tag);
    exp_t e;
    longint acc = 0;
    bit sat = 0;
    int sk = 0, pd = 0;
    int n = va.size();
    if (sep) drv(0, 1, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      while (gap > 0 && int'($urandom % 100) < gap) junk();
      if (vc[i] == 2) acc += va[i];
      else if (vc[i] == 1) acc -= va[i];
      else if (vc[i] == 0) begin if (sk < CMAX) sk++; end
      else begin if (pd < CMAX) pd++; end
      if (acc > LIM_HI) begin acc = LIM_HI; sat = 1; end
      if (acc < LIM_LO) begin acc = LIM_LO; sat = 1; end
      if (i == n - 1) begin
        e.sum = acc; e.sat = sat; e.skip = sk; e.pad = pd; e.tag = tag;
        scb.push_back(e);
        last_sum = acc;
      end
      drv(1, (!sep && i == 0), (i == n - 1), va[i], vc[i]);
    end
    idle();
  endtask

  task automatic fill(input int n, input int a, input int c);
    va = new[n]; vc = new[n];
    for (int i = 0; i < n; i++) begin va[i] = a; vc[i] = c; end
  endtask

  task automatic fill_rand(input int n, input bit with_pad);
    va = new[n]; vc = new[n];
    for (int i = 0; i < n; i++) begin
      va[i] = int'($urandom % 256) - 128;
      vc[i] = with_pad ? int'($urandom % 4) : int'($urandom % 3);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (scb.size() != 0 && t < 20) begin @(negedge clk); t++; end
    chk(scb.size() == 0, "R7 result not produced", scb.size(), 0);
  endtask

  // Monitor: pops an expected result for every done cycle.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_done) begin
      if (scb.size() == 0) begin
        chk(0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = scb.pop_front();
        chk(longint'(out_sum) == e.sum, {e.tag, " sum"}, longint'(out_sum), e.sum);
        chk(out_sat == e.sat, "R10 flag", out_sat, e.sat);
        chk(int'(out_skip) == e.skip, "R4 skip", out_skip, e.skip);
        chk(int'(out_pad) == e.pad, "R5 pad", out_pad, e.pad);
      end
    end
    if (cyc > 100000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_done && out_sum == 0 && !out_sat && out_skip == 0 && out_pad == 0,
        "R1 reset outputs", longint'(out_sum), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_done && out_sum == 0 && out_skip == 0 && out_pad == 0,
        "R1 after release", longint'(out_sum), 0);

    // R2: plus-one weights pass activations through
    va = '{5, -3, 127, -128}; vc = '{2, 2, 2, 2};
    send(0, 0, "R2");
    // R3: minus-one weights negate, including -128
    va = '{5, -3, 127, -128}; vc = '{1, 1, 1, 1};
    send(0, 0, "R3");
    // R4/R5: zero and pad codes contribute nothing, counted apart
    va = '{100, 7, -50, 9, 1, 2}; vc = '{0, 2, 3, 0, 3, 3};
    send(0, 0, "R4 R5");
    // R9: random terms with invalid junk cycles between them
    fill_rand(200, 1);
    send(0, 40, "R9");
    // R6: start alone, then terms without start
    fill_rand(30, 1);
    send(1, 20, "R6 separate start");
    // R6/R7: single term carrying start and last together
    va = '{-77}; vc = '{1};
    send(0, 0, "R6 R7 single");
    drain();

    // R8: result held across idle cycles
    repeat (5) junk();
    @(negedge clk);
    chk(!out_done && longint'(out_sum) == last_sum, "R8 hold", longint'(out_sum), last_sum);
    // R8/R6: lone start clears outputs next cycle
    drv(0, 1, 0, 0, 0);
    idle();
    @(negedge clk);
    chk(out_sum == 0 && !out_sat && out_skip == 0 && out_pad == 0 && !out_done,
        "R8 start clears", longint'(out_sum), 0);

    // R11: full-length exact extremes
    fill(1024, -128, 1);
    send(0, 0, "R11 max positive");
    fill(1024, -128, 2);
    send(0, 0, "R11 max negative");
    // R10: positive and negative saturation
    fill(2070, 127, 2);
    send(0, 0, "R10 clamp high");
    fill(2060, -128, 2);
    send(0, 0, "R10 clamp low");
    // R10: flag cleared by next start; back-to-back sequences
    fill_rand(50, 0);
    send(0, 0, "R10 cleared");
    fill_rand(20, 1);
    send(0, 10, "R7 back to back");
    drain();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule